// File: doc/BRIEF.md
# Receive/Transmit DMA Bus Arbiter with FIFO-Level Hysteresis

This block decides which of two DMA channels, receive or transmit, owns the system bus for the next burst. It also states how many words that burst may carry. Each channel raises a level request and presents the burst length it wants. The arbiter grants one channel, latches the permitted length on `max_burst`, and keeps the grant until the bus side has reported that many accepted beats on `beat_ok`. At the edge of the last beat it re-arbitrates straight away, so back-to-back grants lose no cycle.

The receive channel can take priority based on how full its FIFO is. When threshold arbitration is on, the receive channel gains priority once its fill level reaches an upper bound, and it keeps that priority until the level falls to a lower bound. Both bounds are given in eighths of the FIFO depth. Without that priority, ties alternate between the two channels.

The permitted length works in two steps. First the requested length is capped by a tenure limit field. The capped value is then rounded down to a multiple of the largest enabled burst size (4, 8 or 16 beats) that fits within it. If no enabled size fits, the grant carries a single beat.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While `rst_n` is low and afterwards until the first grant, `rx_gnt`, `tx_gnt` and `max_burst` are 0, receive priority is clear, and the first tie goes to the receive channel. `max_burst` reads 0 whenever no grant is held.
- R2: At most one grant is high at a time. A grant starts only for a channel whose request was high in the cycle before, and with no request pending both grants stay low.
- R3: With no receive priority and both channels requesting at a grant decision, the grant goes to the channel that did not hold the previous grant.
- R4: With `thr_en`=1, receive priority becomes set one clock after `rx_level` >= `thr_hi`*FIFO_DEPTH/8. A level below that bound, when priority is clear, does not set it. While priority is set and `rx_req` is high, the receive channel wins every decision.
- R5: Receive priority is held while the level stays strictly between the lower bound `thr_lo`*FIFO_DEPTH/8 and the upper bound. It clears one clock after the level is at or below the lower bound.
- R6: With `thr_en`=0, receive priority is never set, whatever the level, and decisions follow R3.
- R7: The tenure limit `burst_lim` caps the requested length: code 0 sets no cap (all ones of LEN_W), 1 caps at 16, 2 at 32 and 3 at 64 words.
- R8: `burst_caps` bit 0 enables 4-beat bursts, bit 1 enables 8-beat bursts and bit 2 enables 16-beat bursts. The granted length is the capped length rounded down to a multiple of the largest enabled size that does not exceed it.
- R9: When no enabled size fits the capped length (this includes a requested length of 0 and `burst_caps`=0), the granted length is 1.
- R10: A grant and its `max_burst` stay unchanged until `max_burst` beats have been accepted (`beat_ok` high while granted). At the edge of the last beat the next decision takes effect. `beat_ok` has no effect while no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_req | input | 1 | Receive channel requests the bus |
| tx_req | input | 1 | Transmit channel requests the bus |
| rx_level | input | LVL_W | Receive FIFO fill level in words |
| rx_len | input | LEN_W | Burst length wanted by the receive channel |
| tx_len | input | LEN_W | Burst length wanted by the transmit channel |
| beat_ok | input | 1 | One beat of the current grant was accepted |
| thr_en | input | 1 | Enables level-based receive priority |
| thr_hi | input | 3 | Upper bound in eighths of FIFO depth |
| thr_lo | input | 3 | Lower bound in eighths of FIFO depth |
| burst_lim | input | 2 | Tenure limit code (0 none, 1:16, 2:32, 3:64) |
| burst_caps | input | 3 | Enabled burst sizes: bit0=4, bit1=8, bit2=16 |
| rx_gnt | output | 1 | Receive channel owns the bus |
| tx_gnt | output | 1 | Transmit channel owns the bus |
| max_burst | output | LEN_W | Beats permitted in the current grant |

## Verification
The bench builds the block with FIFO_DEPTH=32 and LEN_W=8. One eighth of the FIFO is then 4 words, so both threshold bounds and the level just on either side of them can be driven exactly. The uncapped limit becomes 255, so with limit code 0 a request of 200 exercises rounding without any cap. Short lengths keep every tenure brief, so the run covers long alternation sequences, hysteresis holds, and beat streams that are either continuous or gapped.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   // tenure limit codes
   typedef enum logic [1:0] {
      LIM_NONE = 2'd0,
      LIM_W16  = 2'd1,
      LIM_W32  = 2'd2,
      LIM_W64  = 2'd3
   } tenure_lim_e;

   // number of selectable burst sizes (4, 8, 16 beats)
   localparam int CAP_N     = 3;
   localparam int CAP_BASE  = 4;
   localparam int BOUND_W   = 3;
   localparam int EIGHTHS   = 8;
endpackage

// File: rtl/rx_prio_tracker.sv
module rx_prio_tracker
   import dma_arb_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               thr_en,
   input  logic [BOUND_W-1:0] hi_code,
   input  logic [BOUND_W-1:0] lo_code,
   input  logic [LVL_W-1:0]   level,
   output logic               prio_o
);
   localparam int STEP = FIFO_DEPTH / EIGHTHS;

   logic [LVL_W-1:0] hi_lvl;
   logic [LVL_W-1:0] lo_lvl;
   logic             prio_q;

   assign hi_lvl = LVL_W'(32'(hi_code) * STEP);
   assign lo_lvl = LVL_W'(32'(lo_code) * STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_q <= 1'b0;
      end else if (!thr_en) begin
         prio_q <= 1'b0;
      end else if (level >= hi_lvl) begin
         prio_q <= 1'b1;
      end else if (level <= lo_lvl) begin
         prio_q <= 1'b0;
      end
   end

   assign prio_o = prio_q;

   // R4
   prio_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_en && level >= hi_lvl) |=> prio_q);

   // R5
   prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_en && level < hi_lvl && level > lo_lvl) |=> (prio_q == $past(prio_q)));

   // R6
   prio_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !thr_en |=> !prio_q);
endmodule

// File: rtl/burst_sizer.sv
module burst_sizer
   import dma_arb_pkg::*;
#(
   parameter int LEN_W = 11
) (
   input  logic [LEN_W-1:0] req_len,
   input  logic [1:0]       lim_code,
   input  logic [CAP_N-1:0] caps,
   output logic [LEN_W-1:0] size_o
);
   localparam logic [LEN_W-1:0] UNCAPPED = '1;

   logic [LEN_W-1:0] limit;
   logic [LEN_W-1:0] capped;
   logic [LEN_W-1:0] sized;
   logic             found;

   always_comb begin
      unique case (tenure_lim_e'(lim_code))
         LIM_W16: limit = LEN_W'(16);
         LIM_W32: limit = LEN_W'(32);
         LIM_W64: limit = LEN_W'(64);
         default: limit = UNCAPPED;
      endcase
   end

   assign capped = (req_len < limit) ? req_len : limit;

   always_comb begin
      sized = LEN_W'(1);
      found = 1'b0;
      for (int k = CAP_N - 1; k >= 0; k--) begin
         if (!found && caps[k] && (capped >= LEN_W'(CAP_BASE << k))) begin
            sized = capped & ~LEN_W'((CAP_BASE << k) - 1);
            found = 1'b1;
         end
      end
   end

   assign size_o = sized;

   always_comb begin
      // R9
      size_nonzero_chk: assert (size_o != '0);
      // R8
      size_fits_chk: assert (size_o <= capped || capped == '0);
   end
endmodule

// File: rtl/grant_engine.sv
module grant_engine #(
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_req,
   input  logic             tx_req,
   input  logic             rx_prio,
   input  logic             beat_ok,
   input  logic [LEN_W-1:0] rx_size,
   input  logic [LEN_W-1:0] tx_size,
   output logic             rx_gnt,
   output logic             tx_gnt,
   output logic [LEN_W-1:0] max_burst
);
   logic             rx_gnt_q;
   logic             tx_gnt_q;
   logic             last_rx_q;
   logic [LEN_W-1:0] remain_q;
   logic [LEN_W-1:0] burst_q;
   logic             busy;
   logic             last_beat;
   logic             decide;
   logic             want_rx;
   logic             want_tx;

   assign busy      = rx_gnt_q | tx_gnt_q;
   assign last_beat = busy && beat_ok && (remain_q == LEN_W'(1));
   assign decide    = !busy || last_beat;
   assign want_rx   = rx_req && (rx_prio || !tx_req || !last_rx_q);
   assign want_tx   = tx_req && !want_rx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_gnt_q  <= 1'b0;
         tx_gnt_q  <= 1'b0;
         last_rx_q <= 1'b0;
         remain_q  <= '0;
         burst_q   <= '0;
      end else if (decide) begin
         rx_gnt_q <= want_rx;
         tx_gnt_q <= want_tx;
         if (want_rx) begin
            remain_q  <= rx_size;
            burst_q   <= rx_size;
            last_rx_q <= 1'b1;
         end else if (want_tx) begin
            remain_q  <= tx_size;
            burst_q   <= tx_size;
            last_rx_q <= 1'b0;
         end else begin
            remain_q <= '0;
            burst_q  <= '0;
         end
      end else if (beat_ok) begin
         remain_q <= remain_q - LEN_W'(1);
      end
   end

   assign rx_gnt    = rx_gnt_q;
   assign tx_gnt    = tx_gnt_q;
   assign max_burst = burst_q;

   // R2
   gnt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_gnt_q, tx_gnt_q}));

   // R2
   gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_gnt_q) |-> $past(rx_req));

   // R3
   rr_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && rx_req && tx_req && !rx_prio && last_rx_q) |=> tx_gnt_q);

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last_beat) |=> $stable({rx_gnt_q, tx_gnt_q, burst_q}));

   // R1
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (burst_q == '0));
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
   import dma_arb_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int LEN_W      = 11,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_req,
   input  logic             tx_req,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LEN_W-1:0] rx_len,
   input  logic [LEN_W-1:0] tx_len,
   input  logic             beat_ok,
   input  logic             thr_en,
   input  logic [2:0]       thr_hi,
   input  logic [2:0]       thr_lo,
   input  logic [1:0]       burst_lim,
   input  logic [2:0]       burst_caps,
   output logic             rx_gnt,
   output logic             tx_gnt,
   output logic [LEN_W-1:0] max_burst
);
   localparam int N_CH = 2;

   if (FIFO_DEPTH < EIGHTHS || (FIFO_DEPTH % EIGHTHS) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a non-zero multiple of 8");
   end
   if (LEN_W < 7) begin : g_bad_len
      $error("LEN_W must hold a 64-word tenure");
   end
   if (LVL_W < $clog2(FIFO_DEPTH + 1)) begin : g_bad_lvl
      $error("LVL_W too narrow for FIFO_DEPTH");
   end

   logic             rx_prio;
   logic [LEN_W-1:0] len_in [N_CH];
   logic [LEN_W-1:0] size_out [N_CH];

   assign len_in[0] = rx_len;
   assign len_in[1] = tx_len;

   rx_prio_tracker #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .LVL_W      (LVL_W)
   ) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .thr_en  (thr_en),
      .hi_code (thr_hi),
      .lo_code (thr_lo),
      .level   (rx_level),
      .prio_o  (rx_prio)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_sizer
      burst_sizer #(
         .LEN_W (LEN_W)
      ) u_sizer (
         .req_len  (len_in[c]),
         .lim_code (burst_lim),
         .caps     (burst_caps),
         .size_o   (size_out[c])
      );
   end

   grant_engine #(
      .LEN_W (LEN_W)
   ) u_grant (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_req    (rx_req),
      .tx_req    (tx_req),
      .rx_prio   (rx_prio),
      .beat_ok   (beat_ok),
      .rx_size   (size_out[0]),
      .tx_size   (size_out[1]),
      .rx_gnt    (rx_gnt),
      .tx_gnt    (tx_gnt),
      .max_burst (max_burst)
   );
endmodule

// File: tb/tb_dma_bus_arbiter.sv
module tb_dma_bus_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int B_DEPTH    = 32;
   localparam int B_LEN      = 8;
   localparam int B_LVL      = $clog2(B_DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx_req = 1'b0, tx_req = 1'b0;
   logic [B_LVL-1:0] rx_level = '0;
   logic [B_LEN-1:0] rx_len = '0, tx_len = '0;
   logic             beat_ok = 1'b0;
   logic             thr_en = 1'b0;
   logic [2:0]       thr_hi = 3'd6, thr_lo = 3'd2;
   logic [1:0]       burst_lim = 2'd0;
   logic [2:0]       burst_caps = 3'b111;
   logic             rx_gnt, tx_gnt;
   logic [B_LEN-1:0] max_burst;

   int tests = 0;
   int fails = 0;

   int    q_chan[$];
   int    q_len[$];
   string q_tag[$];
   int    rx_pend = 0, tx_pend = 0;
   int    remaining = 0;
   int    cur_chan = 0;
   int    cur_len = 0;
   bit    sparse = 1'b0;
   bit    tog = 1'b0;
   bit    model_last_rx = 1'b0;

   dma_bus_arbiter #(.FIFO_DEPTH(B_DEPTH), .LEN_W(B_LEN)) dut (
      .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .tx_req(tx_req),
      .rx_level(rx_level), .rx_len(rx_len), .tx_len(tx_len), .beat_ok(beat_ok),
      .thr_en(thr_en), .thr_hi(thr_hi), .thr_lo(thr_lo), .burst_lim(burst_lim),
      .burst_caps(burst_caps), .rx_gnt(rx_gnt), .tx_gnt(tx_gnt), .max_burst(max_burst)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string tag, string what, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_len(int len, int code, bit [2:0] caps);
      int lim, c;
      lim = (code == 0) ? ((1 << B_LEN) - 1) : (code == 1) ? 16 : (code == 2) ? 32 : 64;
      c = (len < lim) ? len : lim;
      for (int k = 2; k >= 0; k--)
         if (caps[k] && c >= (4 << k)) return (c / (4 << k)) * (4 << k);
      return 1;
   endfunction

   // monitor: pops expected grants and drives beats and requests
   always @(negedge clk) begin
      if (rst_n) begin
         if (remaining > 0) begin
            check("R10", "held grant", {rx_gnt, tx_gnt}, cur_chan == 0 ? 2 : 1);
            check("R10", "held length", max_burst, cur_len);
         end else if (rx_gnt || tx_gnt) begin
            if (rx_gnt && tx_gnt) check("R2", "both grants", 1, 0);
            if (q_chan.size() == 0) begin
               check("R2", "unexpected grant", {rx_gnt, tx_gnt}, 0);
               remaining = max_burst;
            end else begin
               cur_chan = rx_gnt ? 0 : 1;
               cur_len  = max_burst;
               check(q_tag[0], "granted channel (0=rx)", cur_chan, q_chan[0]);
               check(q_tag[0], "granted length", cur_len, q_len[0]);
               void'(q_chan.pop_front());
               void'(q_len.pop_front());
               void'(q_tag.pop_front());
               remaining = cur_len;
            end
            if (rx_gnt && rx_pend > 0) rx_pend--;
            else if (tx_gnt && tx_pend > 0) tx_pend--;
         end
         if (remaining > 0) begin
            beat_ok = sparse ? tog : 1'b1;
            if (beat_ok) remaining--;
         end else begin
            beat_ok = 1'b0;
         end
         tog = ~tog;
         rx_req = (rx_pend > 0);
         tx_req = (tx_pend > 0);
      end
   end

   task automatic wait_cycles(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // driver: pushes expected grants and starts the requests
   task automatic run_pair(string tag, int nrx, int ntx, bit prio);
      int a = nrx, b = ntx;
      int lr = exp_len(rx_len, burst_lim, burst_caps);
      int lt = exp_len(tx_len, burst_lim, burst_caps);
      while (a > 0 || b > 0) begin
         if (a > 0 && (prio || b == 0 || !model_last_rx)) begin
            q_chan.push_back(0); q_len.push_back(lr); q_tag.push_back(tag);
            a--; model_last_rx = 1'b1;
         end else begin
            q_chan.push_back(1); q_len.push_back(lt); q_tag.push_back(tag);
            b--; model_last_rx = 1'b0;
         end
      end
      @(negedge clk); #1;
      rx_pend = nrx;
      tx_pend = ntx;
      while (q_chan.size() != 0 || rx_pend != 0 || tx_pend != 0 || remaining != 0)
         wait_cycles(1);
      wait_cycles(3);
      check("R2", "idle grants", {rx_gnt, tx_gnt}, 0);
      check("R1", "idle max_burst", max_burst, 0);
   endtask

   task automatic single_rx(string tag, int len, int code, bit [2:0] caps);
      rx_len = len[B_LEN-1:0];
      burst_lim = code[1:0];
      burst_caps = caps;
      run_pair(tag, 1, 0, 1'b0);
   endtask

   initial begin
      repeat (200000 - 100) @(posedge clk);
      fails++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      wait_cycles(4);
      check("R1", "reset rx_gnt", rx_gnt, 0);
      check("R1", "reset tx_gnt", tx_gnt, 0);
      check("R1", "reset max_burst", max_burst, 0);
      rst_n = 1'b1;
      // R10: beats while idle have no effect
      beat_ok = 1'b1;
      wait_cycles(3);
      check("R10", "beat while idle", {rx_gnt, tx_gnt}, 0);

      // R3 alternation, first tie to rx (R1)
      rx_len = 8'd16; tx_len = 8'd8;
      run_pair("R3", 2, 2, 1'b0);
      run_pair("R3", 3, 1, 1'b0);

      // R6: full FIFO but threshold arbitration off
      rx_level = 6'd32;
      wait_cycles(3);
      run_pair("R6", 2, 2, 1'b0);

      // R4: level exactly at upper bound 6/8 of 32 = 24
      thr_en = 1'b1; thr_hi = 3'd6; thr_lo = 3'd2;
      rx_level = 6'd24;
      wait_cycles(3);
      run_pair("R4", 2, 2, 1'b1);
      // R5: between bounds, priority held
      rx_level = 6'd10;
      wait_cycles(3);
      run_pair("R5", 2, 2, 1'b1);
      rx_level = 6'd9;
      wait_cycles(3);
      run_pair("R5", 1, 2, 1'b1);
      // R5: at lower bound 8, priority clears
      rx_level = 6'd8;
      wait_cycles(3);
      run_pair("R5", 2, 2, 1'b0);
      // R4: just below upper bound from cleared state
      rx_level = 6'd23;
      wait_cycles(3);
      run_pair("R4", 2, 2, 1'b0);
      // R4: priority with only transmit requesting still grants transmit
      rx_level = 6'd30;
      wait_cycles(3);
      run_pair("R4", 0, 2, 1'b1);
      thr_en = 1'b0;
      wait_cycles(3);

      // R7 tenure limits
      single_rx("R7", 100, 1, 3'b111);
      single_rx("R7", 100, 2, 3'b111);
      single_rx("R7", 100, 3, 3'b111);
      single_rx("R7", 100, 0, 3'b111);
      single_rx("R7", 200, 0, 3'b111);
      single_rx("R7", 40,  3, 3'b001);

      // R8 rounding to enabled sizes
      single_rx("R8", 30, 0, 3'b001);
      single_rx("R8", 30, 0, 3'b010);
      single_rx("R8", 6,  0, 3'b011);
      single_rx("R8", 20, 0, 3'b100);
      single_rx("R8", 12, 0, 3'b110);

      // R9 single-beat fallback
      single_rx("R9", 30, 0, 3'b000);
      single_rx("R9", 10, 0, 3'b100);
      single_rx("R9", 0,  0, 3'b111);
      single_rx("R9", 3,  2, 3'b111);

      // R10 gapped beats
      sparse = 1'b1;
      burst_lim = 2'd0; burst_caps = 3'b111;
      rx_len = 8'd8; tx_len = 8'd4;
      run_pair("R10", 2, 2, 1'b0);
      rx_len = 8'd1; tx_len = 8'd1;
      burst_caps = 3'b000;
      run_pair("R10", 2, 2, 1'b0);
      sparse = 1'b0;
      run_pair("R10", 3, 3, 1'b0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule